// File: doc/BRIEF.md
# Receive Descriptor Ring Tracker

This block keeps the bookkeeping for a circular ring of 16-byte receive descriptors. Software programs the ring size in bytes, moves the tail index, and sets an enable bit, a buffer-size select and a low-space fraction in a control word. The receive datapath marks the start of each incoming frame, pulses once for every descriptor it fills, and marks the end of the frame. The block advances the head index, reports whether a frame of a given byte count would fit in the free buffers, and flags frames that overrun the ring.

A small state machine has two states. **IDLE** waits for a frame. **ACTIVE** covers one frame in progress. It has four named transitions. *accept* (IDLE to ACTIVE) happens on a frame start when the head lies inside the ring. *reject* (IDLE to IDLE, with an overrun) happens on a frame start when the head is at or beyond the ring's entry count. *lap* (ACTIVE to IDLE, with an overrun) happens when a consumed descriptor brings the head back to the index it held at frame start. *close* (ACTIVE to IDLE) happens on a frame end, and the low-space check is made at that moment. Overruns are counted in a saturating missed-frame counter.

Top module: `rxring_tracker`

## Requirements
- R1: While ACTIVE, each `desc_consumed` moves the head to head+1. The head instead becomes 0 when (head+1)×16 ≥ ring length in bytes.
- R2: When `frame_size` ≤ buffer size, `frame_fits` is 1 exactly when head ≠ tail (with reception enabled).
- R3: When `frame_size` > buffer size, the free count is tail−head if head<tail, ring_len/16+tail−head if head>tail, and 0 if they are equal. `frame_fits` is 1 when frame_size ≤ free × buffer size. Arithmetic is modulo 2^17.
- R4: The buffer size comes from control bits [17:16]: 0→2048, 1→1024, 2→512, 3→256 bytes.
- R5: The low-space shift is 1 after reset. A control write sets it to bits [9:8] + 1.
- R6: On *close*, `low_space_irq` pulses for exactly the following cycle when (unwrapped tail − head)×16 ≤ ring_len >> shift. The tail is unwrapped by adding ring_len/16 when tail < head.
- R7: A tail write keeps only data bits [15:0]. A length write keeps only the bits under mask 0xFFF80.
- R8: *reject* and *lap* each raise `overrun` for one cycle and leave the state machine in IDLE. After *lap* the head keeps its advanced value.
- R9: Each overrun adds one to `miss_count`, which holds at all-ones instead of wrapping.
- R10: While control bit 1 (receive enable) is 0, `frame_fits` is 0.
- R11: In IDLE, `desc_consumed` and `frame_end` have no effect. In ACTIVE, `frame_start` has no effect, and a `frame_end` in the same cycle as `desc_consumed` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr | input | 1 | Ring length write strobe |
| len_wdata | input | 32 | Ring length in bytes |
| tail_wr | input | 1 | Tail write strobe |
| tail_wdata | input | 32 | Tail index |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: bit 1 enable, [9:8] low-space select, [17:16] buffer select |
| frame_size | input | 16 | Byte count of the frame being asked about |
| frame_start | input | 1 | A frame begins |
| desc_consumed | input | 1 | One descriptor was filled |
| frame_end | input | 1 | The frame was stored |
| frame_fits | output | 1 | Enough free buffers for `frame_size` |
| head_idx | output | 16 | Current head index |
| overrun | output | 1 | One-cycle overrun pulse |
| low_space_irq | output | 1 | One-cycle low-free-space pulse |
| miss_count | output | 16 | Saturating missed-frame count |

## Verification
The assertions check, on every cycle, properties that need no arithmetic model. In IDLE the head never moves. In ACTIVE it steps by one or wraps to zero. The irq pulse never lasts two cycles. The miss counter moves in step with overruns and sticks at its ceiling. Stored tail and length values are masked correctly, and the fit flag is low while reception is disabled. Other results depend on a model of the free-space formulas, the wrap point and the low-space threshold for particular ring sizes and fractions. These cover whether a given frame size fits, when *lap* fires, and whether the irq is due. Only the bench's reference model, run through directed and random traffic, can show them.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int DESC_SHIFT   = 4;   // 16-byte descriptors
    localparam int LEN_KEEP_LSB = 7;   // ring length granularity
    localparam int CTL_EN_BIT   = 1;
    localparam int CTL_THR_LSB  = 8;
    localparam int CTL_BSEL_LSB = 16;
    localparam int BUF_W        = 12;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } rxr_state_e;

    function automatic logic [BUF_W-1:0] buf_size(input logic [1:0] sel);
        return 12'd2048 >> sel;
    endfunction
endpackage

// File: rtl/rxr_ctl_regs.sv
module rxr_ctl_regs
    import rxr_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [31:0]      len_wdata,
    input  logic             tail_wr,
    input  logic [31:0]      tail_wdata,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_wdata,
    output logic [LEN_W-1:0] ring_len,
    output logic [IDX_W-1:0] tail,
    output logic             rx_en,
    output logic [BUF_W-1:0] buf_bytes,
    output logic [2:0]       thr_shift
);
    logic [1:0] bsel_q;
    logic       unused_bits;

    assign unused_bits = ^{len_wdata[31:LEN_W], len_wdata[LEN_KEEP_LSB-1:0],
                           tail_wdata[31:IDX_W], ctl_wdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_len  <= '0;
            tail      <= '0;
            rx_en     <= 1'b0;
            bsel_q    <= 2'd0;
            thr_shift <= 3'd1;
        end else begin
            if (len_wr)
                ring_len <= {len_wdata[LEN_W-1:LEN_KEEP_LSB], {LEN_KEEP_LSB{1'b0}}};
            if (tail_wr)
                tail <= tail_wdata[IDX_W-1:0];
            if (ctl_wr) begin
                rx_en     <= ctl_wdata[CTL_EN_BIT];
                bsel_q    <= ctl_wdata[CTL_BSEL_LSB +: 2];
                thr_shift <= {1'b0, ctl_wdata[CTL_THR_LSB +: 2]} + 3'd1;
            end
        end
    end

    assign buf_bytes = buf_size(bsel_q);

    p_tail_low16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tail_wr |=> tail == $past(tail_wdata[IDX_W-1:0]));
    p_len_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr |=> ring_len[LEN_KEEP_LSB-1:0] == '0);
    p_shift_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (thr_shift >= 3'd1 && thr_shift <= 3'd4));
endmodule

// File: rtl/rxr_avail.sv
module rxr_avail
    import rxr_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int LEN_W  = 20,
    parameter int SIZE_W = 16
) (
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  tail,
    input  logic [LEN_W-1:0]  ring_len,
    input  logic              rx_en,
    input  logic [BUF_W-1:0]  buf_bytes,
    input  logic [SIZE_W-1:0] frame_size,
    output logic              fits
);
    localparam int ENT_W  = LEN_W - DESC_SHIFT;
    localparam int FREE_W = ((IDX_W > ENT_W) ? IDX_W : ENT_W) + 1;
    localparam int CAP_W  = FREE_W + BUF_W;

    logic [FREE_W-1:0] ents, hd, tl, free;
    logic [CAP_W-1:0]  cap, need;
    logic              single;

    always_comb begin
        ents = FREE_W'(ring_len >> DESC_SHIFT);
        hd   = FREE_W'(head);
        tl   = FREE_W'(tail);
        if (hd < tl)
            free = tl - hd;
        else if (hd > tl)
            free = ents + tl - hd;
        else
            free = '0;
        cap    = CAP_W'(free) * CAP_W'(buf_bytes);
        need   = CAP_W'(frame_size);
        single = need <= CAP_W'(buf_bytes);
        fits   = rx_en && (single ? (head != tail) : (need <= cap));
    end
endmodule

// File: rtl/rxr_head_fsm.sv
module rxr_head_fsm
    import rxr_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int LEN_W = 20,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             desc_consumed,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] ring_len,
    input  logic [IDX_W-1:0] tail,
    input  logic [2:0]       thr_shift,
    output logic [IDX_W-1:0] head,
    output logic             overrun,
    output logic             low_irq,
    output logic [CNT_W-1:0] miss_count
);
    localparam int ENT_W  = LEN_W - DESC_SHIFT;
    localparam int FREE_W = ((IDX_W > ENT_W) ? IDX_W : ENT_W) + 1;
    localparam int NXT_W  = IDX_W + 1 + DESC_SHIFT;
    localparam int CMP_W  = (NXT_W > LEN_W) ? NXT_W : LEN_W;
    localparam int GAP_W  = ((FREE_W + DESC_SHIFT) > LEN_W) ? (FREE_W + DESC_SHIFT) : LEN_W;
    localparam logic [CNT_W-1:0] MISS_MAX = '1;

    rxr_state_e        state_q, state_d;
    logic [IDX_W-1:0]  start_q, head_adv;
    logic [IDX_W:0]    head_inc;
    logic [FREE_W-1:0] ents, hd, tl, rdt, gap;
    logic              wrap, start_bad, low_hit;
    logic              ev_adv, ev_ovr, ev_low, ev_take;

    always_comb begin
        head_inc  = {1'b0, head} + 1'b1;
        wrap      = CMP_W'({head_inc, {DESC_SHIFT{1'b0}}}) >= CMP_W'(ring_len);
        head_adv  = wrap ? '0 : head_inc[IDX_W-1:0];
        ents      = FREE_W'(ring_len >> DESC_SHIFT);
        hd        = FREE_W'(head);
        tl        = FREE_W'(tail);
        start_bad = hd >= ents;
        rdt       = (tl < hd) ? (tl + ents) : tl;
        gap       = rdt - hd;
        low_hit   = GAP_W'({gap, {DESC_SHIFT{1'b0}}}) <= GAP_W'(ring_len >> thr_shift);
    end

    // next-state and event decode
    always_comb begin
        state_d = state_q;
        ev_adv  = 1'b0;
        ev_ovr  = 1'b0;
        ev_low  = 1'b0;
        ev_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) begin
                    ev_take = 1'b1;
                    if (start_bad) ev_ovr = 1'b1;          // reject
                    else           state_d = ST_ACTIVE;    // accept
                end
            end
            ST_ACTIVE: begin
                if (desc_consumed) begin
                    ev_adv = 1'b1;
                    if (head_adv == start_q) begin         // lap
                        ev_ovr  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (frame_end) begin              // close
                    ev_low  = low_hit;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            if (ev_take) start_q <= head;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head       <= '0;
            overrun    <= 1'b0;
            low_irq    <= 1'b0;
            miss_count <= '0;
        end else begin
            if (ev_adv) head <= head_adv;
            overrun <= ev_ovr;
            low_irq <= ev_low;
            if (ev_ovr && miss_count != MISS_MAX)
                miss_count <= miss_count + 1'b1;
        end
    end

    p_head_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && desc_consumed) |=> (head == '0 || head == $past(head) + 1'b1));
    p_idle_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> head == $past(head));
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_irq |=> !low_irq);
    p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == MISS_MAX) |=> miss_count == MISS_MAX);
    p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && $past(miss_count) != MISS_MAX) |-> miss_count == $past(miss_count) + 1'b1);
    p_ovr_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> state_q == ST_IDLE);
endmodule

// File: rtl/rxring_tracker.sv
module rxring_tracker
    import rxr_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int LEN_W  = 20,
    parameter int SIZE_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_wr,
    input  logic [31:0]       len_wdata,
    input  logic              tail_wr,
    input  logic [31:0]       tail_wdata,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    input  logic [SIZE_W-1:0] frame_size,
    input  logic              frame_start,
    input  logic              desc_consumed,
    input  logic              frame_end,
    output logic              frame_fits,
    output logic [IDX_W-1:0]  head_idx,
    output logic              overrun,
    output logic              low_space_irq,
    output logic [CNT_W-1:0]  miss_count
);
    logic [LEN_W-1:0] ring_len;
    logic [IDX_W-1:0] tail;
    logic             rx_en;
    logic [BUF_W-1:0] buf_bytes;
    logic [2:0]       thr_shift;

    rxr_ctl_regs #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
        .clk, .rst_n, .len_wr, .len_wdata, .tail_wr, .tail_wdata,
        .ctl_wr, .ctl_wdata, .ring_len, .tail, .rx_en, .buf_bytes, .thr_shift
    );

    rxr_avail #(.IDX_W(IDX_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_avail (
        .head(head_idx), .tail, .ring_len, .rx_en, .buf_bytes,
        .frame_size, .fits(frame_fits)
    );

    rxr_head_fsm #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk, .rst_n, .frame_start, .desc_consumed, .frame_end,
        .ring_len, .tail, .thr_shift, .head(head_idx), .overrun,
        .low_irq(low_space_irq), .miss_count
    );

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !frame_fits);
endmodule

// File: tb/test_rxring_tracker.sv
module test_rxring_tracker;
    localparam int CW = 4;
    localparam int MISS_MAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_wr = 0, tail_wr = 0, ctl_wr = 0;
    logic [31:0] len_wdata = 0, tail_wdata = 0, ctl_wdata = 0;
    logic [15:0] frame_size = 0;
    logic        frame_start = 0, desc_consumed = 0, frame_end = 0;
    logic        frame_fits, overrun, low_space_irq;
    logic [15:0] head_idx;
    logic [CW-1:0] miss_count;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rxring_tracker #(.CNT_W(CW)) i_rxring_tracker (
        .clk, .rst_n, .len_wr, .len_wdata, .tail_wr, .tail_wdata,
        .ctl_wr, .ctl_wdata, .frame_size, .frame_start, .desc_consumed,
        .frame_end, .frame_fits, .head_idx, .overrun, .low_space_irq, .miss_count
    );

    // behavioural reference model
    int m_head, m_tail, m_len, m_en, m_bsel, m_shift, m_state, m_start;
    int m_ovr, m_irq, m_miss;

    always @(posedge clk) begin
        int ents, nh, rdt, gap, n_head, n_state, n_ovr, n_irq;
        if (!rst_n) begin
            m_head = 0; m_tail = 0; m_len = 0; m_en = 0; m_bsel = 0; m_shift = 1;
            m_state = 0; m_start = 0; m_ovr = 0; m_irq = 0; m_miss = 0;
        end else begin
            ents = m_len >> 4;
            nh = m_head + 1;
            if (nh * 16 >= m_len) nh = 0;
            n_head = m_head; n_state = m_state; n_ovr = 0; n_irq = 0;
            if (m_state == 0) begin
                if (frame_start) begin
                    m_start = m_head;
                    if (m_head >= ents) n_ovr = 1; else n_state = 1;
                end
            end else if (desc_consumed) begin
                n_head = nh;
                if (nh == m_start) begin n_ovr = 1; n_state = 0; end
            end else if (frame_end) begin
                rdt = (m_tail < m_head) ? m_tail + ents : m_tail;
                gap = (rdt - m_head) & 'h1FFFF;
                if (gap * 16 <= (m_len >> m_shift)) n_irq = 1;
                n_state = 0;
            end
            if (n_ovr != 0 && m_miss < MISS_MAX) m_miss = m_miss + 1;
            if (len_wr)  m_len  = int'(len_wdata & 32'hFFF80);
            if (tail_wr) m_tail = int'(tail_wdata & 32'hFFFF);
            if (ctl_wr) begin
                m_en = ctl_wdata[1]; m_bsel = ctl_wdata[17:16]; m_shift = ctl_wdata[9:8] + 1;
            end
            m_head = n_head; m_state = n_state; m_ovr = n_ovr; m_irq = n_irq;
        end
    end

    function automatic int mfits(int sz);
        int bsz, ents, fr;
        bsz = 2048 >> m_bsel;
        ents = m_len >> 4;
        if (m_en == 0) return 0;
        if (sz <= bsz) return (m_head != m_tail) ? 1 : 0;
        if (m_head < m_tail) fr = m_tail - m_head;
        else if (m_head > m_tail) fr = (ents + m_tail - m_head) & 'h1FFFF;
        else fr = 0;
        return (longint'(sz) <= longint'(fr) * bsz) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R1 head", int'(head_idx), m_head);
            chk(m_en == 0 ? "R10 fits" : (int'(frame_size) <= (2048 >> m_bsel) ? "R2 fits" : "R3 fits"),
                int'(frame_fits), mfits(int'(frame_size)));
            chk("R8 overrun", int'(overrun), m_ovr);
            chk("R6 irq", int'(low_space_irq), m_irq);
            chk("R9 miss", int'(miss_count), m_miss);
        end
    end

    task automatic wr_len(input logic [31:0] v);
        @(negedge clk); len_wr = 1; len_wdata = v; @(negedge clk); len_wr = 0;
    endtask
    task automatic wr_tail(input logic [31:0] v);
        @(negedge clk); tail_wr = 1; tail_wdata = v; @(negedge clk); tail_wr = 0;
    endtask
    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v; @(negedge clk); ctl_wr = 0;
    endtask
    task automatic p_start();
        @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    endtask
    task automatic p_desc();
        @(negedge clk); desc_consumed = 1; @(negedge clk); desc_consumed = 0;
    endtask
    task automatic p_end();
        @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #6;
        chk("R1 reset head", int'(head_idx), 0);
        chk("R10 reset fits", int'(frame_fits), 0);
        chk("R9 reset miss", int'(miss_count), 0);
        chk("R6 reset irq", int'(low_space_irq), 0);

        // ring of 16 entries, 2048-byte buffers, half threshold, tail 4
        wr_len(32'h0000_017F);
        wr_tail(32'h0001_0004);
        wr_ctl(32'h0000_0002);
        frame_size = 100;  #6; chk("R2 small fits", int'(frame_fits), 1);
        frame_size = 8192; #1; chk("R3 exact cap", int'(frame_fits), 1);
        frame_size = 8193; #1; chk("R3 over cap", int'(frame_fits), 0);
        frame_size = 8192; #1; chk("R7 tail masked", int'(frame_fits), 1);

        p_start(); p_desc(); p_desc(); p_end();
        #6; chk("R6 irq raised", int'(low_space_irq), 1);
        chk("R1 head two", int'(head_idx), 2);

        // buffer 512, eighth threshold
        wr_ctl(32'h0002_0202);
        frame_size = 1024; #6; chk("R4 512 buffers", int'(frame_fits), 1);
        frame_size = 1025; #1; chk("R4 512 over", int'(frame_fits), 0);
        wr_tail(32'd10);
        p_start(); p_desc(); p_end();
        #6; chk("R5 shift three no irq", int'(low_space_irq), 0);

        // wrap through the end of the ring
        wr_tail(32'd1);
        frame_size = 3000; #6; chk("R3 wrapped free", int'(frame_fits), 1);
        p_start();
        for (int i = 0; i < 14; i++) p_desc();
        p_end();
        #6; chk("R1 wrapped head", int'(head_idx), 1);
        frame_size = 10; #1; chk("R2 equal indices", int'(frame_fits), 0);

        // lap overrun
        p_start();
        for (int i = 0; i < 15; i++) p_desc();
        @(negedge clk); desc_consumed = 1; @(negedge clk); desc_consumed = 0;
        #6; chk("R8 lap pulse", int'(overrun), 1);
        chk("R9 one miss", int'(miss_count), 1);
        p_desc(); p_end();
        #6; chk("R11 idle ignores", int'(head_idx), 1);

        // consume and end together: end ignored
        p_start();
        @(negedge clk); desc_consumed = 1; frame_end = 1;
        @(negedge clk); desc_consumed = 0; frame_end = 0;
        p_desc();
        #6; chk("R11 end dropped", int'(head_idx), 3);
        p_end();

        // reject overruns until saturation
        wr_len(32'd0);
        for (int i = 0; i < 20; i++) p_start();
        #6; chk("R9 saturate", int'(miss_count), MISS_MAX);

        // disable gates availability
        wr_len(32'h100);
        wr_ctl(32'h0003_0000);
        frame_size = 5; #6; chk("R10 disabled", int'(frame_fits), 0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            len_wr        = ($urandom_range(0, 40) == 0);
            len_wdata     = $urandom_range(0, 32'h7FF);
            tail_wr       = ($urandom_range(0, 6) == 0);
            tail_wdata    = {$urandom_range(0, 3), 16'($urandom_range(0, 40))};
            ctl_wr        = ($urandom_range(0, 30) == 0);
            ctl_wdata     = $urandom | 32'h2;
            frame_size    = 16'($urandom_range(0, 12000));
            frame_start   = ($urandom_range(0, 5) == 0);
            desc_consumed = ($urandom_range(0, 2) == 0);
            frame_end     = ($urandom_range(0, 6) == 0);
        end
        @(negedge clk);
        len_wr = 0; tail_wr = 0; ctl_wr = 0;
        frame_start = 0; desc_consumed = 0; frame_end = 0;
        repeat (2) @(negedge clk);
        #7;
        finish_up();
    end
endmodule